// File: doc/BRIEF.md
# Real-Time Clock Peripheral with Slow-Domain Sync Tracking

This block is a register-mapped real-time clock. It keeps a 32-bit seconds counter that advances on an external once-per-second strobe. It compares that counter against an alarm register, and it runs a watchdog that counts down on an external millisecond strobe. It also holds two persistent control words. The seconds, alarm and both persistent words stand for registers in a slow, always-powered domain. A bus write first lands in a shadow copy. The value takes effect only after a transfer of `XFER_CYC` bus-clock cycles, and while that transfer runs the register's stale flag reads as 1 in the status word. Software writes a value, polls the flag until it reads 0, and only then trusts a read-back.

The control register and persistent word 0 each have a write-one-to-set alias and a write-one-to-clear alias. A single bit can therefore be changed without a read-modify-write. There are two resets. `por_n` clears the whole block, slow domain included. `rst_n` clears only the control register and the watchdog, so that time, alarm and persistent state survive a system reset.

Each sync slot is a two-state machine. IDLE goes to XFER on a write. XFER goes back to XFER on a further write, which reloads the count. XFER goes to IDLE when the count expires, and that is the cycle in which the value commits. The watchdog has three states. IDLE goes to COUNT when it is enabled with a nonzero count. COUNT goes to IDLE when the enable is cleared or the count is already zero. COUNT goes to FIRE on the tick that takes the count from 1 to 0. FIRE always returns to IDLE after one cycle.

Top module: `rtc_core`

## Requirements
- R1: After reset the status word reads 0x8000_0000: bit 31 is the always-1 presence flag, and every stale flag is 0. The control register and the watchdog count read 0, and an unmapped offset such as 0x20 reads 0.
- R2: Control sits at offset 0x00 (direct write), 0x04 (each 1 bit sets that bit) and 0x08 (each 1 bit clears that bit). Only bits 0 (alarm interrupt enable), 1 (millisecond interrupt enable), 2 (alarm pending) and 4 (watchdog enable) are stored. All other bits read 0.
- R3: A write to seconds (0x30), alarm (0x40), persistent 0 (0x60/0x64/0x68) or persistent 1 (0x70) sets its status stale flag: bit 23, 22, 16 or 17 in that order. The flag stays set for exactly `XFER_CYC` cycles after the write edge. Reads return the old value until the flag drops, and the new value from then on.
- R4: A further write to a register whose stale flag is set restarts its transfer. The flag then stays set for `XFER_CYC` cycles from the latest write, and the latest value is the one that commits.
- R5: Each cycle with `sec_tick` high increments the committed seconds counter by one, wrapping from 0xFFFF_FFFF to 0.
- R6: When persistent 0 bit 2 is 1 and the seconds counter becomes equal to the alarm register, control bit 2 sets on the next cycle. `alarm_irq` equals control bit 2 AND control bit 0. Writing bit 2 through 0x08 clears the pending flag, and it does not set again while the match merely persists.
- R7: When the pending flag is set while persistent 0 bit 1 is 1, persistent 0 bit 7 latches to 1.
- R8: Offsets 0x64 and 0x68 set and clear bits of persistent word 0. They operate on the pending shadow value when a transfer is in progress, and on the committed value otherwise.
- R9: Writing offset 0x50 loads the watchdog count. While control bit 4 is 1 and the count is nonzero, each `ms_tick` decrements it. The tick that reaches zero makes `wdog_rst` high for exactly one cycle. While control bit 4 is 0 the count holds.
- R10: `rst_n` low clears the control register and the watchdog count but leaves seconds, alarm and persistent words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, clears control and watchdog |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write when `bus_sel` is high |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| sec_tick | input | 1 | One-cycle strobe once per second |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| alarm_irq | output | 1 | Alarm interrupt request |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
A slot machine stuck in XFER shows at the status port as a stale flag that never drops after `XFER_CYC` cycles. A slot that leaves XFER early shows as the new value appearing a cycle or more too soon. The bench samples both on the exact cycle around the commit. A watchdog state machine that skips FIRE or stays in it shows on `wdog_rst` on the tick that reaches zero, or on the cycle after that tick. A wrong pending or match state shows on `alarm_irq` and on the control read-back one cycle after the matching second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam logic [7:0] OFF_CTRL     = 8'h00;
    localparam logic [7:0] OFF_CTRL_SET = 8'h04;
    localparam logic [7:0] OFF_CTRL_CLR = 8'h08;
    localparam logic [7:0] OFF_STAT     = 8'h10;
    localparam logic [7:0] OFF_SEC      = 8'h30;
    localparam logic [7:0] OFF_ALARM    = 8'h40;
    localparam logic [7:0] OFF_WDOG     = 8'h50;
    localparam logic [7:0] OFF_P0       = 8'h60;
    localparam logic [7:0] OFF_P0_SET   = 8'h64;
    localparam logic [7:0] OFF_P0_CLR   = 8'h68;
    localparam logic [7:0] OFF_P1       = 8'h70;

    localparam int CB_ALM_IE   = 0;
    localparam int CB_MS_IE    = 1;
    localparam int CB_ALM_PEND = 2;
    localparam int CB_WD_EN    = 4;

    localparam int PB_WAKE_EN   = 1;
    localparam int PB_ALM_EN    = 2;
    localparam int PB_WAKE_SEEN = 7;

    localparam int STALE_LSB = 16;
    localparam int PRESENT_BIT = 31;

    localparam int SL_SEC  = 0;
    localparam int SL_ALM  = 1;
    localparam int SL_P0   = 2;
    localparam int SL_P1   = 3;
    localparam int N_SLOTS = 4;

    typedef enum logic {
        SLOT_IDLE,
        SLOT_XFER
    } slot_state_e;

    typedef enum logic [1:0] {
        WD_IDLE,
        WD_COUNT,
        WD_FIRE
    } wd_state_e;
endpackage

// File: rtl/rtc_sync_slot.sv
module rtc_sync_slot
    import rtc_pkg::*;
#(
    parameter int DW       = 32,
    parameter int XFER_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ldata,
    output logic [DW-1:0] shadow,
    output logic          stale,
    output logic          commit
);
    localparam int CW = $clog2(XFER_CYC + 1);

    slot_state_e st, st_n;
    logic [CW-1:0] cnt;

    always_comb begin
        st_n = st;
        unique case (st)
            SLOT_IDLE: st_n = load ? SLOT_XFER : SLOT_IDLE;
            SLOT_XFER: begin
                if (load)                  st_n = SLOT_XFER;
                else if (cnt == CW'(1))    st_n = SLOT_IDLE;
                else                       st_n = SLOT_XFER;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SLOT_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            shadow <= '0;
        end else if (load) begin
            cnt    <= CW'(XFER_CYC);
            shadow <= ldata;
        end else if (st == SLOT_XFER) begin
            cnt <= cnt - CW'(1);
        end
    end

    always_comb begin
        stale  = (st == SLOT_XFER);
        commit = (st == SLOT_XFER) && !load && (cnt == CW'(1));
    end

    AST_LOAD_MARKS_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> stale); // R3
    AST_COMMIT_ENDS_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !stale); // R4
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog
    import rtc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] ldata,
    output logic [DW-1:0] count,
    output logic          fire
);
    wd_state_e st, st_n;

    always_comb begin
        st_n = st;
        unique case (st)
            WD_IDLE:  st_n = (en && count != '0) ? WD_COUNT : WD_IDLE;
            WD_COUNT: begin
                if (!en)                              st_n = WD_IDLE;
                else if (load)                        st_n = WD_COUNT;
                else if (tick && count == DW'(1))     st_n = WD_FIRE;
                else if (count == '0)                 st_n = WD_IDLE;
                else                                  st_n = WD_COUNT;
            end
            WD_FIRE:  st_n = WD_IDLE;
            default:  st_n = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WD_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         count <= '0;
        else if (load)                                      count <= ldata;
        else if (st == WD_COUNT && en && tick && count != '0) count <= count - DW'(1);
    end

    always_comb fire = (st == WD_FIRE);

    AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R9
    AST_FIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (count == '0)); // R9
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(count)); // R9
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DW       = 32,
    parameter int XFER_CYC = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              sec_tick,
    input  logic              ms_tick,
    output logic              alarm_irq,
    output logic              wdog_rst
);
    localparam logic [DW-1:0] CTRL_MASK = DW'((1 << CB_ALM_IE) | (1 << CB_MS_IE) |
                                              (1 << CB_ALM_PEND) | (1 << CB_WD_EN));

    logic wr_en;
    logic hit_ctrl, hit_cset, hit_cclr, hit_stat, hit_sec, hit_alm, hit_wd;
    logic hit_p0, hit_p0s, hit_p0c, hit_p1;

    always_comb begin
        wr_en    = bus_sel && bus_wr;
        hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
        hit_cset = (bus_addr == ADDR_W'(OFF_CTRL_SET));
        hit_cclr = (bus_addr == ADDR_W'(OFF_CTRL_CLR));
        hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
        hit_sec  = (bus_addr == ADDR_W'(OFF_SEC));
        hit_alm  = (bus_addr == ADDR_W'(OFF_ALARM));
        hit_wd   = (bus_addr == ADDR_W'(OFF_WDOG));
        hit_p0   = (bus_addr == ADDR_W'(OFF_P0));
        hit_p0s  = (bus_addr == ADDR_W'(OFF_P0_SET));
        hit_p0c  = (bus_addr == ADDR_W'(OFF_P0_CLR));
        hit_p1   = (bus_addr == ADDR_W'(OFF_P1));
    end

    // slow-domain committed registers
    logic [DW-1:0] sec_q, alarm_q, p0_q, p1_q;
    logic          match_q;

    // sync slots
    logic [N_SLOTS-1:0] s_load, s_stale, s_commit;
    logic [DW-1:0]      s_ldata  [N_SLOTS];
    logic [DW-1:0]      s_shadow [N_SLOTS];
    logic [DW-1:0]      p0_base;

    always_comb begin
        p0_base = s_stale[SL_P0] ? s_shadow[SL_P0] : p0_q;
        s_load[SL_SEC] = wr_en && hit_sec;
        s_load[SL_ALM] = wr_en && hit_alm;
        s_load[SL_P0]  = wr_en && (hit_p0 || hit_p0s || hit_p0c);
        s_load[SL_P1]  = wr_en && hit_p1;
        s_ldata[SL_SEC] = bus_wdata;
        s_ldata[SL_ALM] = bus_wdata;
        s_ldata[SL_P1]  = bus_wdata;
        if (hit_p0)       s_ldata[SL_P0] = bus_wdata;
        else if (hit_p0s) s_ldata[SL_P0] = p0_base | bus_wdata;
        else              s_ldata[SL_P0] = p0_base & ~bus_wdata;
    end

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        rtc_sync_slot #(.DW(DW), .XFER_CYC(XFER_CYC)) u_slot (
            .clk    (clk),
            .rst_n  (por_n),
            .load   (s_load[i]),
            .ldata  (s_ldata[i]),
            .shadow (s_shadow[i]),
            .stale  (s_stale[i]),
            .commit (s_commit[i])
        );
    end

    // alarm compare
    logic match, alarm_rise;
    always_comb begin
        match      = p0_q[PB_ALM_EN] && (sec_q == alarm_q);
        alarm_rise = match && !match_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sec_q   <= '0;
            alarm_q <= '0;
            p0_q    <= '0;
            p1_q    <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= match;
            if (s_commit[SL_SEC])  sec_q <= s_shadow[SL_SEC];
            else if (sec_tick)     sec_q <= sec_q + DW'(1);
            if (s_commit[SL_ALM])  alarm_q <= s_shadow[SL_ALM];
            if (s_commit[SL_P0])   p0_q <= s_shadow[SL_P0];
            else if (alarm_rise && p0_q[PB_WAKE_EN]) p0_q[PB_WAKE_SEEN] <= 1'b1;
            if (s_commit[SL_P1])   p1_q <= s_shadow[SL_P1];
        end
    end

    // control register with set/clear aliases
    logic [DW-1:0] ctrl_q, ctrl_n;
    always_comb begin
        ctrl_n = ctrl_q;
        if (wr_en) begin
            if (hit_ctrl)      ctrl_n = bus_wdata;
            else if (hit_cset) ctrl_n = ctrl_q | bus_wdata;
            else if (hit_cclr) ctrl_n = ctrl_q & ~bus_wdata;
        end
        if (alarm_rise) ctrl_n[CB_ALM_PEND] = 1'b1;
        ctrl_n = ctrl_n & CTRL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_n;
    end

    // watchdog
    logic [DW-1:0] wd_count;
    rtc_wdog #(.DW(DW)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl_q[CB_WD_EN]),
        .tick  (ms_tick),
        .load  (wr_en && hit_wd),
        .ldata (bus_wdata),
        .count (wd_count),
        .fire  (wdog_rst)
    );

    // status and read mux
    logic [DW-1:0] stat;
    always_comb begin
        stat = '0;
        stat[PRESENT_BIT]   = 1'b1;
        stat[STALE_LSB + 0] = s_stale[SL_P0];
        stat[STALE_LSB + 1] = s_stale[SL_P1];
        stat[STALE_LSB + 6] = s_stale[SL_ALM];
        stat[STALE_LSB + 7] = s_stale[SL_SEC];
    end

    always_comb begin
        if (hit_ctrl || hit_cset || hit_cclr)   bus_rdata = ctrl_q;
        else if (hit_stat)                      bus_rdata = stat;
        else if (hit_sec)                       bus_rdata = sec_q;
        else if (hit_alm)                       bus_rdata = alarm_q;
        else if (hit_wd)                        bus_rdata = wd_count;
        else if (hit_p0 || hit_p0s || hit_p0c)  bus_rdata = p0_q;
        else if (hit_p1)                        bus_rdata = p1_q;
        else                                    bus_rdata = '0;
    end

    always_comb alarm_irq = ctrl_q[CB_ALM_IE] && ctrl_q[CB_ALM_PEND];

    AST_SEC_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_q) |-> ($past(sec_tick) || $past(s_commit[SL_SEC]))); // R5
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_cclr && bus_wdata[CB_ALM_PEND] && !alarm_rise) |=> !ctrl_q[CB_ALM_PEND]); // R6
endmodule

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
    localparam int XFER = 8;

    logic        clk = 1'b0;
    logic        por_n, rst_n, bus_sel, bus_wr, sec_tick, ms_tick;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        alarm_irq, wdog_rst;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rtc_core #(.ADDR_W(8), .DW(32), .XFER_CYC(XFER)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_tick(sec_tick), .ms_tick(ms_tick), .alarm_irq(alarm_irq), .wdog_rst(wdog_rst)
    );

    function automatic logic [31:0] ctrl_model(input logic [31:0] old, input int op,
                                               input logic [31:0] d);
        logic [31:0] r;
        if (op == 0)      r = d;
        else if (op == 1) r = old | d;
        else              r = old & ~d;
        return r & 32'h17;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stick();
        sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic mtick();
        ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, r, m, old, s;
        void'($urandom(32'd2024));
        por_n = 1'b0; rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0; sec_tick = 1'b0; ms_tick = 1'b0;
        cyc(3);
        por_n = 1'b1; rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(8'h10, r); check("R1 status", r, 32'h8000_0000);
        rd(8'h00, r); check("R1 ctrl", r, 32'h0);
        rd(8'h50, r); check("R1 wdog", r, 32'h0);
        rd(8'h20, r); check("R1 unmapped", r, 32'h0);

        // R2 random alias traffic on control
        m = 32'h0;
        for (int i = 0; i < 24; i++) begin
            int op;
            op = int'($urandom % 3);
            v  = $urandom;
            wr(op == 0 ? 8'h00 : (op == 1 ? 8'h04 : 8'h08), v);
            m = ctrl_model(m, op, v);
            rd(8'h08, r); check("R2 ctrl alias", r, m);
            check("R6 irq from ctrl", {31'b0, alarm_irq}, {31'b0, m[0] & m[2]});
        end
        wr(8'h00, 32'h0);

        // R3 and R5 random seconds writes
        for (int i = 0; i < 4; i++) begin
            rd(8'h30, old);
            v = (i == 3) ? 32'hFFFF_FFFF : $urandom;
            wr(8'h30, v);
            rd(8'h10, r); check("R3 stale set", r, 32'h8080_0000);
            rd(8'h30, r); check("R3 old value while stale", r, old);
            cyc(XFER - 1);
            rd(8'h10, r); check("R3 stale at last cycle", r, 32'h8080_0000);
            cyc(1);
            rd(8'h10, r); check("R3 stale dropped", r, 32'h8000_0000);
            rd(8'h30, r); check("R3 committed", r, v);
            for (int n = 1; n <= 3; n++) begin
                stick();
                rd(8'h30, r); check("R5 tick", r, v + 32'(n));
            end
        end

        // R4 restart while stale
        wr(8'h40, 32'h1234_0000);
        cyc(4);
        wr(8'h40, 32'hDEAD_0000);
        cyc(XFER - 1);
        rd(8'h10, r); check("R4 stale restarted", r, 32'h8040_0000);
        rd(8'h40, r); check("R4 not yet", r, 32'h0);
        cyc(1);
        rd(8'h10, r); check("R4 stale dropped", r, 32'h8000_0000);
        rd(8'h40, r); check("R4 latest wins", r, 32'hDEAD_0000);

        // R8 persistent 0 aliases, stacked on shadow
        wr(8'h60, 32'h0000_0100);
        wr(8'h64, 32'h0000_0006);
        rd(8'h10, r); check("R3 p0 stale", r, 32'h8001_0000);
        cyc(XFER);
        rd(8'h60, r); check("R8 set on shadow", r, 32'h0000_0106);
        wr(8'h68, 32'h0000_0100);
        cyc(XFER);
        rd(8'h60, r); check("R8 clear", r, 32'h0000_0006);
        wr(8'h70, 32'h8000_0000);
        rd(8'h10, r); check("R3 p1 stale", r, 32'h8002_0000);
        cyc(XFER);
        rd(8'h70, r); check("R3 p1 commit", r, 32'h8000_0000);

        // R6 and R7 alarm
        rd(8'h30, s);
        wr(8'h40, s + 32'd2);
        cyc(XFER);
        stick();
        cyc(1);
        rd(8'h00, r); check("R6 no early pend", r, 32'h0);
        stick();
        cyc(1);
        rd(8'h00, r); check("R6 pend set", r, 32'h4);
        check("R6 irq masked", {31'b0, alarm_irq}, 32'h0);
        rd(8'h60, r); check("R7 wake latched", r, 32'h86);
        wr(8'h04, 32'h1);
        check("R6 irq on", {31'b0, alarm_irq}, 32'h1);
        wr(8'h08, 32'h4);
        cyc(3);
        check("R6 irq cleared", {31'b0, alarm_irq}, 32'h0);
        rd(8'h00, r); check("R6 pend stays clear", r, 32'h1);

        // R9 watchdog countdown
        wr(8'h50, 32'd3);
        wr(8'h04, 32'h10);
        cyc(1);
        mtick();
        rd(8'h50, r); check("R9 dec 1", r, 32'd2);
        check("R9 no fire", {31'b0, wdog_rst}, 32'h0);
        mtick();
        rd(8'h50, r); check("R9 dec 2", r, 32'd1);
        mtick();
        check("R9 fire", {31'b0, wdog_rst}, 32'h1);
        rd(8'h50, r); check("R9 zero", r, 32'd0);
        cyc(1);
        check("R9 one-cycle pulse", {31'b0, wdog_rst}, 32'h0);
        wr(8'h50, 32'd5);
        cyc(1);
        mtick(); mtick();
        wr(8'h08, 32'h10);
        for (int k = 0; k < 3; k++) begin
            mtick();
            check("R9 halted no fire", {31'b0, wdog_rst}, 32'h0);
        end
        rd(8'h50, r); check("R9 halted", r, 32'd3);

        // R10 system reset keeps slow domain
        wr(8'h04, 32'h13);
        rd(8'h30, s);
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
        rd(8'h00, r); check("R10 ctrl cleared", r, 32'h0);
        rd(8'h50, r); check("R10 wdog cleared", r, 32'h0);
        rd(8'h30, r); check("R10 seconds kept", r, s);
        rd(8'h60, r); check("R10 p0 kept", r, 32'h86);
        rd(8'h70, r); check("R10 p1 kept", r, 32'h8000_0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule